// File: doc/BRIEF.md
# TDM Audio Serial Slot Port

This block is one participant on a shared four-wire time-division-multiplexed audio bus made of a bit clock, a frame marker, a data line into the port and a data line out of it. Every participant owns one 64-bit window of each frame. A frame holds one, two or four such windows, so up to four ports can share the wires. Outgoing data changes on the bit-clock rising edge. Incoming data is captured on the falling edge, so every bit lasts exactly one bit-clock period.

A port runs in one of two modes. As timing master it divides the system clock down to make the bit clock and the frame marker, and it drives both onto the bus. As follower it takes both signals from the bus, where they are synchronous to the system clock, and aligns its bit counter to the falling edge of the frame marker. On the system side, a 64-bit transmit word is taken in at the start of every frame. The word received in the port's own window is presented with a one-cycle strobe. The output driver is enabled only inside the selected window.

Top module: `tdm_slot_port`

## Requirements
- R1: With `cfg_master` high, `sclk_oe` and `fsync_oe` are high, and `sclk_o` is a square wave with a period of 2*HALF_DIV system clocks (8 by default). With `cfg_master` low, both enables are low.
- R2: As master, the frame marker goes high at the bit-clock rise that begins bit L-3 of the frame. It stays high for exactly one bit-clock period, so it falls two bit periods before bit 0. It rises once per frame.
- R3: `cfg_frame_sel` sets the frame length L in bit-clock periods: 0 gives 64, 1 gives 128, and 2 or 3 gives 256.
- R4: As follower, the frame marker is sampled on bit-clock falling edges. Bit 0 begins at the second bit-clock rise after the rise in which the marker was seen to drop, and this holds for any high width of one or more bit periods.
- R5: Transmit data is sent MSB first. Bit k of the window carries `tx_word[63-k]` and changes at bit-clock rises. `tx_word` is captured at the rise that starts bit 0 of each frame.
- R6: `sdout_oe` is high only during frame bits `cfg_slot*64` through `cfg_slot*64+63`. A slot index that lies beyond the frame never drives. `sdout_o` is 0 whenever `sdout_oe` is low.
- R7: Receive bits are sampled from `sdin_i` on bit-clock falls, MSB first. After the fall of the last bit of the window, `rx_word` takes the 64 sampled bits and `rx_valid` pulses for exactly one system clock, once per frame.
- R8: After reset, `sdout_oe`, `rx_valid` and `rx_word` are zero. The port neither drives nor reports until it has seen a frame-marker fall followed by a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = generate bit clock and frame marker |
| cfg_frame_sel | input | 2 | Frame length select (R3) |
| cfg_slot | input | 2 | Index of the 64-bit window this port owns |
| tx_word | input | 64 | Word to send in the next frame |
| rx_word | output | 64 | Last word received in the own window |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |
| sclk_i | input | 1 | Bus bit clock (follower mode) |
| sclk_o | output | 1 | Generated bit clock |
| sclk_oe | output | 1 | Drive enable for `sclk_o` |
| fsync_i | input | 1 | Bus frame marker (follower mode) |
| fsync_o | output | 1 | Generated frame marker |
| fsync_oe | output | 1 | Drive enable for `fsync_o` |
| sdin_i | input | 1 | Serial data into the port |
| sdout_o | output | 1 | Serial data out of the port |
| sdout_oe | output | 1 | Drive enable for `sdout_o` |

## Verification
The hardest case to reach is a follower whose frame marker is not the one-period pulse a master port makes. Only a stretched marker shows that alignment keys on the falling edge and not on the high level. To produce it, the bench switches the bus source from the master instance to its own bit-clock generator. That generator holds the marker high for three bit periods, and all four instances run as followers in permuted slots. A second hard case is a slot index that lies outside a short frame. The 64- and 128-bit runs place followers on such slots, and any drive or strobe they produce is flagged.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOT_BITS_DEF = 64;
  localparam int SLOTS_DEF     = 4;
  localparam int HALF_DIV_DEF  = 4;

  typedef logic [1:0] frame_sel_t;

  // log2 of the number of windows selected, clipped to the supported maximum
  function automatic int slots_log(frame_sel_t sel, int max_log);
    int v;
    v = (sel > 2'd2) ? 2 : int'(sel);
    if (v > max_log) v = max_log;
    return v;
  endfunction
endpackage

// File: rtl/tdm_sclk_gen.sv
module tdm_sclk_gen
  import tdm_pkg::*;
#(
  parameter int HALF_DIV = HALF_DIV_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic sclk_i,
  output logic sclk_o,
  output logic rise,
  output logic fall
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic             sclk_q, sclk_d;
  logic             sq1_q, sq2_q;
  logic             tick;

  assign tick = (div_q == DIV_W'(HALF_DIV - 1));

  always_comb begin
    div_d  = div_q;
    sclk_d = sclk_q;
    if (master) begin
      div_d  = tick ? '0 : div_q + 1'b1;
      sclk_d = tick ? ~sclk_q : sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
      sq1_q  <= 1'b0;
      sq2_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
      sq1_q  <= sclk_i;
      sq2_q  <= sq1_q;
    end
  end

  assign sclk_o = master & sclk_q;
  assign rise   = master ? (tick & ~sclk_q) : (sq1_q & ~sq2_q);
  assign fall   = master ? (tick &  sclk_q) : (~sq1_q & sq2_q);

  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
  a_r1_rise_sets_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (master && rise) |=> (sclk_o || !master));
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_pkg::*;
#(
  parameter int SLOT_BITS = SLOT_BITS_DEF,
  parameter int SLOTS     = SLOTS_DEF
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      master,
  input  frame_sel_t                                frame_sel,
  input  logic                                      rise,
  input  logic                                      fall,
  input  logic                                      fsync_i,
  output logic [$clog2(SLOT_BITS*SLOTS)-1:0]        cnt,
  output logic                                      fsync_o,
  output logic                                      frame_start,
  output logic                                      run
);
  localparam int CNT_W   = $clog2(SLOT_BITS * SLOTS);
  localparam int MAX_LOG = $clog2(SLOTS);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, last;
  logic             fs_q, fs_d, fso_q, fso_d;
  logic             seen_q, seen_d, run_q, run_d;
  logic             fs_src, fall_det, wrap;

  assign last     = CNT_W'((SLOT_BITS << slots_log(frame_sel, MAX_LOG)) - 1);
  assign wrap     = (cnt_q >= last);
  assign cnt_inc  = wrap ? '0 : cnt_q + 1'b1;
  assign fs_src   = master ? fso_q : fsync_i;
  assign fall_det = fall & fs_q & ~fs_src;
  assign frame_start = rise & wrap & seen_q;

  always_comb begin
    cnt_d  = cnt_q;
    fso_d  = fso_q;
    fs_d   = fs_q;
    seen_d = seen_q;
    run_d  = run_q;
    if (rise) begin
      cnt_d = cnt_inc;
      fso_d = master & (cnt_inc == last - CNT_W'(2));
    end
    if (!master) fso_d = 1'b0;
    if (fall) fs_d = fs_src;
    if (fall_det) begin
      cnt_d  = last - CNT_W'(1);
      seen_d = 1'b1;
    end
    if (frame_start) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fso_q  <= 1'b0;
      fs_q   <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fso_q  <= fso_d;
      fs_q   <= fs_d;
      seen_q <= seen_d;
      run_q  <= run_d;
    end
  end

  assign cnt     = cnt_q;
  assign fsync_o = fso_q;
  assign run     = run_q;

  a_r2_marker_one_period: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_o && rise) |=> !fsync_o);
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cnt_q == last && $stable(frame_sel)) |=> (cnt_q == '0));
  a_r4_realign_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_det && $stable(frame_sel)) |=> (cnt_q == last - CNT_W'(1)));
endmodule

// File: rtl/tdm_slot_shift.sv
module tdm_slot_shift
  import tdm_pkg::*;
#(
  parameter int SLOT_BITS = SLOT_BITS_DEF,
  parameter int SLOTS     = SLOTS_DEF
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(SLOT_BITS*SLOTS)-1:0]  cnt,
  input  logic                                run,
  input  logic [$clog2(SLOTS)-1:0]            slot,
  input  logic                                frame_start,
  input  logic                                fall,
  input  logic                                sdin,
  input  logic [SLOT_BITS-1:0]                tx_word,
  output logic                                sdout_o,
  output logic                                sdout_oe,
  output logic [SLOT_BITS-1:0]                rx_word,
  output logic                                rx_valid
);
  localparam int CNT_W = $clog2(SLOT_BITS * SLOTS);
  localparam int OFS_W = $clog2(SLOT_BITS);

  logic [SLOT_BITS-1:0] tx_q, tx_d, sh_q, sh_d, rxw_q, rxw_d;
  logic                 val_q, val_d;
  logic [OFS_W-1:0]     ofs;
  logic                 in_slot, cap;

  assign ofs     = cnt[OFS_W-1:0];
  assign in_slot = run & (cnt[CNT_W-1:OFS_W] == slot);
  assign cap     = fall & in_slot;

  always_comb begin
    tx_d  = frame_start ? tx_word : tx_q;
    sh_d  = cap ? {sh_q[SLOT_BITS-2:0], sdin} : sh_q;
    rxw_d = rxw_q;
    val_d = 1'b0;
    if (cap && (ofs == {OFS_W{1'b1}})) begin
      rxw_d = {sh_q[SLOT_BITS-2:0], sdin};
      val_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      sh_q  <= '0;
      rxw_q <= '0;
      val_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      sh_q  <= sh_d;
      rxw_q <= rxw_d;
      val_q <= val_d;
    end
  end

  assign sdout_oe = in_slot;
  assign sdout_o  = in_slot & tx_q[~ofs];
  assign rx_word  = rxw_q;
  assign rx_valid = val_q;

  a_r6_drive_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    sdout_oe |-> run);
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r7_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fall));
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_pkg::*;
#(
  parameter int HALF_DIV  = HALF_DIV_DEF,
  parameter int SLOT_BITS = SLOT_BITS_DEF,
  parameter int SLOTS     = SLOTS_DEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_master,
  input  logic [1:0]                  cfg_frame_sel,
  input  logic [$clog2(SLOTS)-1:0]    cfg_slot,
  input  logic [SLOT_BITS-1:0]        tx_word,
  output logic [SLOT_BITS-1:0]        rx_word,
  output logic                        rx_valid,
  input  logic                        sclk_i,
  output logic                        sclk_o,
  output logic                        sclk_oe,
  input  logic                        fsync_i,
  output logic                        fsync_o,
  output logic                        fsync_oe,
  input  logic                        sdin_i,
  output logic                        sdout_o,
  output logic                        sdout_oe
);
  localparam int CNT_W = $clog2(SLOT_BITS * SLOTS);

  logic             rise, fall, frame_start, run;
  logic [CNT_W-1:0] cnt;

  tdm_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .rise(rise), .fall(fall)
  );

  tdm_frame_ctr #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_frm (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .frame_sel(cfg_frame_sel),
    .rise(rise), .fall(fall), .fsync_i(fsync_i), .cnt(cnt),
    .fsync_o(fsync_o), .frame_start(frame_start), .run(run)
  );

  tdm_slot_shift #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_shf (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .run(run), .slot(cfg_slot),
    .frame_start(frame_start), .fall(fall), .sdin(sdin_i), .tx_word(tx_word),
    .sdout_o(sdout_o), .sdout_oe(sdout_oe), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  assign sclk_oe  = cfg_master;
  assign fsync_oe = cfg_master;

  a_r8_quiet_until_run: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!sdout_oe && !rx_valid));
endmodule

// File: tb/tdm_slot_port_tb.sv
module tdm_slot_port_tb;
  localparam int HALF = 4;
  localparam int EXT_HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_mode = 1'b0, ext_sclk = 1'b0, ext_fs = 1'b0, sdin = 1'b0;
  logic [1:0] fsel = 2'd0;
  logic [1:0] pslot [4];
  logic [63:0] txw [4];
  logic [63:0] rxw [4];
  logic [3:0] rxv, so, soe, sck, sckoe, fso, fsoe;
  logic bus_sclk, bus_fs;

  int total = 0, bad = 0, L = 64, idx = 0, frames = 0, since_rise = 0;
  bit synced = 0, en = 0, mon_on = 0, fs_prev = 0, sclk_prev = 0, have_rise = 0, done = 0;
  logic [63:0] exp_tx [4];
  logic [63:0] drv [4];
  bit pend [4];

  always #10 clk = ~clk;

  assign bus_sclk = ext_mode ? ext_sclk : sck[0];
  assign bus_fs   = ext_mode ? ext_fs : fso[0];

  tdm_slot_port u_dut (.clk(clk), .rst_n(rst_n), .cfg_master(!ext_mode), .cfg_frame_sel(fsel),
    .cfg_slot(pslot[0]), .tx_word(txw[0]), .rx_word(rxw[0]), .rx_valid(rxv[0]),
    .sclk_i(bus_sclk), .sclk_o(sck[0]), .sclk_oe(sckoe[0]), .fsync_i(bus_fs), .fsync_o(fso[0]),
    .fsync_oe(fsoe[0]), .sdin_i(sdin), .sdout_o(so[0]), .sdout_oe(soe[0]));
  tdm_slot_port u_p1 (.clk(clk), .rst_n(rst_n), .cfg_master(1'b0), .cfg_frame_sel(fsel),
    .cfg_slot(pslot[1]), .tx_word(txw[1]), .rx_word(rxw[1]), .rx_valid(rxv[1]),
    .sclk_i(bus_sclk), .sclk_o(sck[1]), .sclk_oe(sckoe[1]), .fsync_i(bus_fs), .fsync_o(fso[1]),
    .fsync_oe(fsoe[1]), .sdin_i(sdin), .sdout_o(so[1]), .sdout_oe(soe[1]));
  tdm_slot_port u_p2 (.clk(clk), .rst_n(rst_n), .cfg_master(1'b0), .cfg_frame_sel(fsel),
    .cfg_slot(pslot[2]), .tx_word(txw[2]), .rx_word(rxw[2]), .rx_valid(rxv[2]),
    .sclk_i(bus_sclk), .sclk_o(sck[2]), .sclk_oe(sckoe[2]), .fsync_i(bus_fs), .fsync_o(fso[2]),
    .fsync_oe(fsoe[2]), .sdin_i(sdin), .sdout_o(so[2]), .sdout_oe(soe[2]));
  tdm_slot_port u_p3 (.clk(clk), .rst_n(rst_n), .cfg_master(1'b0), .cfg_frame_sel(fsel),
    .cfg_slot(pslot[3]), .tx_word(txw[3]), .rx_word(rxw[3]), .rx_valid(rxv[3]),
    .sclk_i(bus_sclk), .sclk_o(sck[3]), .sclk_oe(sckoe[3]), .fsync_i(bus_fs), .fsync_o(fso[3]),
    .fsync_oe(fsoe[3]), .sdin_i(sdin), .sdout_o(so[3]), .sdout_oe(soe[3]));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // external bit clock: marker high for three bit periods, falling two before bit 0
  initial begin
    int gc = 0, gi = 0;
    forever begin
      @(posedge clk); #1;
      if (!ext_mode || !rst_n) begin
        ext_sclk = 0; ext_fs = 0; gc = 0; gi = 0;
      end else begin
        gc++;
        if (gc == EXT_HALF) begin
          gc = 0;
          ext_sclk = ~ext_sclk;
          if (ext_sclk) begin
            gi = (gi + 1) % L;
            ext_fs = (gi >= L - 5) && (gi <= L - 3);
          end
        end
      end
    end
  end

  // reference model, evaluated away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (!mon_on) begin
        sclk_prev = bus_sclk;
        continue;
      end
      since_rise++;
      if (bus_sclk && !sclk_prev) begin
        if (!ext_mode && have_rise)
          chk(since_rise == 2 * HALF, "R1", "bit clock period", 64'(since_rise), 64'(2 * HALF));
        have_rise = 1; since_rise = 0;
        if (synced) begin
          idx = (idx + 1) % L;
          if (idx == 0) begin
            frames++;
            for (int p = 0; p < 4; p++) exp_tx[p] = txw[p];
          end
          en = (frames >= 2);
          if (idx == L / 2)
            for (int p = 0; p < 4; p++) txw[p] = {$urandom, $urandom};
          if (!ext_mode && en)
            chk(bus_fs == (idx == L - 3), "R2/R3", "marker position", 64'(bus_fs), 64'(idx == L - 3));
          if (idx % 64 == 0) begin
            for (int p = 0; p < 4; p++)
              if (int'(pslot[p]) == idx / 64) begin
                if (pend[p]) chk(0, "R7", "missing receive strobe", 64'(p), 64'(1));
                pend[p] = en;
              end
            drv[idx / 64] = {$urandom, $urandom};
          end
          sdin = drv[idx / 64][63 - idx % 64];
        end
      end
      if (!bus_sclk && sclk_prev) begin
        if (fs_prev && !bus_fs) begin
          if (synced) chk(idx == L - 2, ext_mode ? "R4" : "R2", "marker fall bit", 64'(idx), 64'(L - 2));
          synced = 1; idx = L - 2;
        end
        fs_prev = bus_fs;
        if (en) begin
          for (int p = 0; p < 4; p++) begin
            bit exp_oe;
            exp_oe = (int'(pslot[p]) == idx / 64);
            chk(soe[p] == exp_oe, "R6", $sformatf("drive enable port %0d", p), 64'(soe[p]), 64'(exp_oe));
            if (exp_oe)
              chk(so[p] == exp_tx[p][63 - idx % 64], ext_mode ? "R4/R5" : "R5",
                  $sformatf("data bit %0d port %0d", idx, p), 64'(so[p]), 64'(exp_tx[p][63 - idx % 64]));
            else
              chk(so[p] == 1'b0, "R6", "idle data low", 64'(so[p]), 64'(0));
          end
        end
      end
      sclk_prev = bus_sclk;
      for (int p = 0; p < 4; p++)
        if (rxv[p] && en) begin
          chk(pend[p], "R7", $sformatf("unexpected strobe port %0d", p), 64'(1), 64'(0));
          if (pend[p])
            chk(rxw[p] == drv[pslot[p]], "R7", $sformatf("receive word port %0d", p), rxw[p], drv[pslot[p]]);
          pend[p] = 0;
        end
    end
  end

  task automatic run_case(input bit ext, input logic [1:0] sel, input int frame_len,
                          input logic [1:0] s0, input logic [1:0] s1,
                          input logic [1:0] s2, input logic [1:0] s3);
    mon_on = 0;
    rst_n = 0;
    ext_mode = ext; fsel = sel; L = frame_len;
    pslot[0] = s0; pslot[1] = s1; pslot[2] = s2; pslot[3] = s3;
    for (int p = 0; p < 4; p++) begin
      txw[p] = {$urandom, $urandom}; drv[p] = '0; pend[p] = 0; exp_tx[p] = '0;
    end
    synced = 0; en = 0; frames = 0; idx = 0; fs_prev = 0; have_rise = 0; since_rise = 0; sdin = 0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      chk(soe[p] == 0 && rxv[p] == 0 && rxw[p] == 0, "R8", "reset outputs",
          {soe[p], rxv[p], |rxw[p]}, 64'(0));
    end
    chk(sckoe[0] == !ext && fsoe[0] == !ext, "R1", "port 0 clock drive enables",
        {sckoe[0], fsoe[0]}, {!ext, !ext});
    chk(sckoe[1] == 0 && fsoe[1] == 0, "R1", "follower drive enables", {sckoe[1], fsoe[1]}, 64'(0));
    @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    repeat (2 * HALF) @(negedge clk);
    chk(soe == 4'b0 && rxv == 4'b0, "R8", "idle before first frame", {soe, rxv}, 64'(0));
    wait (frames >= 6);
    @(negedge clk);
  endtask

  initial begin
    run_case(0, 2'd0,  64, 2'd0, 2'd1, 2'd2, 2'd3);
    run_case(0, 2'd1, 128, 2'd0, 2'd1, 2'd2, 2'd3);
    run_case(0, 2'd2, 256, 2'd0, 2'd1, 2'd2, 2'd3);
    run_case(0, 2'd3, 256, 2'd1, 2'd3, 2'd0, 2'd2);
    run_case(1, 2'd2, 256, 2'd2, 2'd0, 2'd3, 2'd1);
    finish_run();
  end

  initial begin
    #(200000 * 20);
    chk(0, "WATCHDOG", "run did not finish", 64'(frames), 64'(6));
    finish_run();
  end
endmodule